// File: doc/BRIEF.md
# Free-Running Interval Timer with Prescaler

This block is an 8-bit up-counter that runs without stopping. It advances on a tick taken from one of eight taps of a 10-bit prescaler, and the prescaler runs from the system clock. Each time the count wraps from 0xFF to 0x00, an interrupt request flag is set. The flag stays set until the interrupt controller clears it. The selected tick is also exported as the counting clock for an external watchdog. With a 4 MHz source, the tap periods run from 2 µs to 256 µs, so a full counter lap can last up to about 65.5 ms.

Software sees one register address. A read returns the live count. A write goes to a small control register: bits 2:0 pick the tap, and writing 1 to bit 3 requests a counter clear. The clear bit is held in a two-state sequencer. A write with bit 3 set takes transition `RUN->CLEAR` into state `ST_CLEAR`, which zeroes the counter. One clock (machine cycle) later, transition `CLEAR->RUN` drops the bit and counting resumes. A further clear request while in `ST_CLEAR` takes the self-loop `CLEAR->CLEAR`. In `ST_RUN` with no request, the counter advances on each tick (`RUN->RUN`).

Top module: `interval_timer`

## Requirements
- R1: In `ST_RUN`, with no clear request, the count read on `rd_count` rises by exactly one on each edge where `wdt_tick` is high. It wraps from 0xFF to 0x00 and never halts, and it does not change on edges where `wdt_tick` is low.
- R2: The edge that takes the count from 0xFF to 0x00 sets `irq_flag`, so `irq_flag` reads 1 one cycle after that edge.
- R3: Select value s in `wr_data[2:0]` (s = 0..7) makes `wdt_tick` pulse once every 8·2^s clock cycles (8, 16, ... 1024).
- R4: After reset, the count is 0x00, `irq_flag` is 0 and the select is 7, so ticks arrive every 1024 cycles.
- R5: A write with `wr_data[3]` = 1 makes the count 0x00 at the write edge. It holds the count at 0x00 through the next edge as well, even if a tick falls on that edge. Counting then resumes on the following ticks.
- R6: A write with `wr_data[3]` = 0 changes only the select. The count keeps its value and its normal stepping.
- R7: Once set, `irq_flag` stays 1 until an edge with `irq_clr` = 1. If a wrap and `irq_clr` fall on the same edge, the flag stays 1.
- R8: `wdt_tick` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (source) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the shared address |
| wr_data | input | 4 | Control write data: [2:0] tap select, [3] clear request |
| irq_clr | input | 1 | Clears the interrupt request flag |
| rd_count | output | 8 | Live counter value (read of the shared address) |
| irq_flag | output | 1 | Interrupt request flag, set on wrap |
| wdt_tick | output | 1 | Selected single-cycle tick, clock enable for the watchdog |

## Verification
A prescaler or tap multiplexer fault shows on `wdt_tick` as a wrong spacing between pulses within two tick periods, which is at most 2048 cycles at the slowest tap. If the sequencer gets stuck in `ST_CLEAR` or leaves it early, `rd_count` shows the error on the first tick after a clear: the count is either pinned at zero or has moved too soon. A wrong wrap or flag priority shows on `irq_flag` in the cycle right after the 0xFF edge.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int CNT_W     = 8;   // counter width
    localparam int TAPS      = 8;   // number of prescaler taps
    localparam int FIRST_TAP = 2;   // prescaler bit giving the divide-by-8 tap
    localparam int CLR_BIT   = 3;   // control write bit that requests a clear

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_CLEAR = 1'b1
    } clr_state_t;
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DIV_W-1:0] div_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> div_q == DIV_W'($past(div_q) + 1'b1)); // R3
endmodule

// File: rtl/itmr_tap_sel.sv
module itmr_tap_sel #(
    parameter int TAPS  = 8,
    parameter int SEL_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAPS-1:0]  div_hi,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [TAPS-1:0] taps;
    logic            sel_tap;
    logic            prev_q;

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        assign taps[g] = div_hi[g];
    end

    assign sel_tap = taps[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel_tap;
    end

    assign tick = sel_tap & ~prev_q;

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R8
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
    import itmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         clr_req,
    output logic [W-1:0] count_q,
    output logic         wrap
);
    clr_state_t   state_q, state_d;
    logic [W-1:0] count_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // next state and counter outputs
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        wrap    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (clr_req) begin
                    state_d = ST_CLEAR;
                    count_d = '0;
                end else if (tick_en) begin
                    count_d = count_q + 1'b1;
                    wrap    = (count_q == {W{1'b1}});
                end
            end
            ST_CLEAR: begin
                count_d = '0;
                state_d = clr_req ? ST_CLEAR : ST_RUN;
            end
        endcase
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !clr_req && tick_en) |=> count_q == W'($past(count_q) + 1'b1)); // R1
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !clr_req && !tick_en) |=> $stable(count_q)); // R1
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> count_q == '0); // R5
    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR && !clr_req) |=> (state_q == ST_RUN && count_q == '0)); // R5
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int W      = CNT_W,
    parameter int NTAPS  = TAPS,
    parameter int TAP0   = FIRST_TAP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [3:0]   wr_data,
    input  logic         irq_clr,
    output logic [W-1:0] rd_count,
    output logic         irq_flag,
    output logic         wdt_tick
);
    localparam int SEL_W = $clog2(NTAPS);
    localparam int DIV_W = TAP0 + NTAPS;

    logic [DIV_W-1:0] div_q;
    logic [SEL_W-1:0] sel_q;
    logic             tick;
    logic             clr_req;
    logic             wrap;

    itmr_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .div_q (div_q)
    );

    // tap select register, resets to the slowest tap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sel_q <= '1;
        else if (wr_en) sel_q <= wr_data[SEL_W-1:0];
    end

    itmr_tap_sel #(.TAPS(NTAPS), .SEL_W(SEL_W)) u_tap (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_hi (div_q[DIV_W-1:TAP0]),
        .sel    (sel_q),
        .tick   (tick)
    );

    assign clr_req = wr_en & wr_data[CLR_BIT];

    itmr_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick),
        .clr_req (clr_req),
        .count_q (rd_count),
        .wrap    (wrap)
    );

    // interrupt flag: set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_flag <= 1'b0;
        else if (wrap)    irq_flag <= 1'b1;
        else if (irq_clr) irq_flag <= 1'b0;
    end

    assign wdt_tick = tick;

    AST_WRAP_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> irq_flag); // R2
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag); // R7
    AST_IRQ_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flag && !wrap) |=> !irq_flag); // R2
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic       irq_clr = 1'b0;
    logic [7:0] rd_count;
    logic       irq_flag;
    logic       wdt_tick;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    interval_timer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .irq_clr  (irq_clr),
        .rd_count (rd_count),
        .irq_flag (irq_flag),
        .wdt_tick (wdt_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 4'h0;
    endtask

    // advance to the next negedge where wdt_tick is high; n = cycles moved
    task automatic wait_tick(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (wdt_tick) break;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(rd_count == 8'h00, "R4 count", rd_count, 0);
        chk(irq_flag == 1'b0, "R4 irq", irq_flag, 0);
    endtask

    task automatic t_default_tap();
        int n;
        wait_tick(n);
        wait_tick(n);
        chk(n == 1024, "R4 default interval", n, 1024);
    endtask

    task automatic t_tap_intervals();
        int n;
        for (int s = 0; s < 8; s++) begin
            wr(4'(s));
            wait_tick(n);
            wait_tick(n);
            chk(n == (8 << s), "R3 tap interval", n, 8 << s);
            @(negedge clk);
            chk(!wdt_tick, "R8 single pulse", wdt_tick, 0);
        end
    endtask

    task automatic t_count_step();
        int n;
        int c;
        wr(4'h0);
        wait_tick(n);
        wait_tick(n);
        c = rd_count;
        @(negedge clk);
        chk(rd_count == 8'(c + 1), "R1 step on tick", rd_count, (c + 1) % 256);
        repeat (3) @(negedge clk);
        chk(rd_count == 8'(c + 1), "R1 hold without tick", rd_count, (c + 1) % 256);
    endtask

    task automatic t_write_no_clear();
        int n;
        int c;
        wait_tick(n);
        c = rd_count;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 4'h0;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_count == 8'(c + 1), "R6 write keeps count", rd_count, (c + 1) % 256);
    endtask

    task automatic t_clear_hold();
        int n;
        wait_tick(n);
        repeat (7) @(negedge clk);
        wr_en = 1'b1; wr_data = 4'h8;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 4'h0;
        chk(rd_count == 8'h00, "R5 cleared", rd_count, 0);
        chk(wdt_tick == 1'b1, "R5 tick on hold edge", wdt_tick, 1);
        @(negedge clk);
        chk(rd_count == 8'h00, "R5 hold over tick", rd_count, 0);
        repeat (7) @(negedge clk);
        chk(rd_count == 8'h00, "R5 still zero", rd_count, 0);
        @(negedge clk);
        chk(rd_count == 8'h01, "R5 resumes", rd_count, 1);
    endtask

    task automatic seek_ff();
        int n;
        for (int i = 0; i < 300; i++) begin
            wait_tick(n);
            if (rd_count == 8'hFF) break;
        end
    endtask

    task automatic t_overflow_irq();
        wr(4'h8);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        seek_ff();
        chk(irq_flag == 1'b0, "R2 no flag before wrap", irq_flag, 0);
        @(negedge clk);
        chk(rd_count == 8'h00, "R1 wrap to zero", rd_count, 0);
        chk(irq_flag == 1'b1, "R2 flag on wrap", irq_flag, 1);
        repeat (20) @(negedge clk);
        chk(irq_flag == 1'b1, "R7 flag sticky", irq_flag, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq_flag == 1'b0, "R7 flag cleared", irq_flag, 0);
    endtask

    task automatic t_irq_race();
        seek_ff();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq_flag == 1'b1, "R7 wrap beats clear", irq_flag, 1);
        chk(rd_count == 8'h00, "R1 wrap in race", rd_count, 0);
    endtask

    initial begin
        t_reset();
        t_default_tap();
        t_tap_intervals();
        t_count_step();
        t_write_no_clear();
        t_clear_hold();
        t_overflow_irq();
        t_irq_race();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule